// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command-register state machine of a byte-wide parallel NOR-style flash controller model. Each qualified write cycle carries an address and a data byte. The block tracks the multi-cycle unlock handshakes that lead to program, erase, erase suspend and resume, identification (autoselect) and reset. It drives a read-mode code that a read multiplexer downstream uses to pick between array data, identification data and status. It also raises one-cycle start requests towards separate program and erase engines, and it reacts to their completion and error flags.

Any write that does not fit the expected next step of a sequence returns the block to array reading. After an erase has been suspended, a read whose address falls inside a sector being erased is flagged as a status read. Reads elsewhere still return array data. The unlock addresses, the unlock bytes and every command code are parameters.

Top module: `flash_cmd_seq`

## Requirements
- R1: The write sequence AA@0x555, 55@0x2AA, A0@0x555, followed by any address/data write, gives a one-cycle `prog_start` in the cycle after that fourth write. In that cycle `op_addr`/`op_data` hold the fourth write's values and `rd_mode` reads 2. Command addresses are compared on `wr_addr[10:0]` only.
- R2: A write whose address or data does not match the next expected step of an unlock or command sequence returns `rd_mode` to 0 (array) in the next cycle. If the erase is suspended, such a write returns `rd_mode` to 3 (suspended) instead.
- R3: While reset is low and right after it, `rd_mode` is 0 and no start request is raised.
- R4: `prog_done` or `erase_done` seen while busy returns `rd_mode` to 0 in the next cycle. If `eng_error` is seen in the same cycle, the error takes priority.
- R5: After AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, the write 10@0x555 starts a whole-chip erase with `erase_all`=1 and every bit of `erase_sectors` set. The write 30@any address instead starts a single-sector erase, where bit `wr_addr[16:14]` is set in `erase_sectors`. In both cases `erase_start` pulses for one cycle.
- R6: B0@any address during an erase gives `rd_mode`=3 and `erase_hold`=1. In that suspended state, 30@any address resumes the erase: `rd_mode` becomes 2 and `erase_hold` becomes 0.
- R7: `rd_is_status` is 1 for every read address when `rd_mode`=2. When `rd_mode`=3 it is 1 only for addresses whose sector (`rd_addr[16:14]`) has its bit set in `erase_sectors`. In modes 0 and 1 it is 0.
- R8: A program sequence issued while suspended starts a program just as R1 describes. Its `prog_done` returns `rd_mode` to 3, not 0.
- R9: The write 90@0x555 after the two unlock writes sets `rd_mode`=1. In that mode every write other than F0 is ignored, and F0@any address returns to mode 0.
- R10: `eng_error` during a program or an erase holds `rd_mode` at 2 until an F0 write. Other writes and done flags have no effect during that time.
- R11: While a program is running, writes cause no start request and do not change `rd_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Qualified write cycle this clock |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | AW | Current read address, for sector redirection |
| prog_done | input | 1 | Program engine finished |
| erase_done | input | 1 | Erase engine finished |
| eng_error | input | 1 | Engine reports a failure |
| rd_mode | output | 2 | 0 array, 1 identification, 2 status, 3 erase suspended |
| rd_is_status | output | 1 | Read at rd_addr must return status |
| prog_start | output | 1 | One-cycle program request |
| erase_start | output | 1 | One-cycle erase request |
| erase_all | output | 1 | Last erase request was whole-chip |
| erase_hold | output | 1 | Erase engine must pause |
| op_addr | output | AW | Program target address |
| op_data | output | 8 | Program data byte |
| erase_sectors | output | SECTORS | Sectors selected by the last erase |

## Verification
Directed sequences run every command path: program, chip erase, sector erase, suspend, program while suspended, resume, identification and reset. Each command path is also run with one corrupted byte at each step of the program and erase sequences, with the address and the data corrupted in turn. This separates a correct match on both fields from a check on only one. Suspended reads are taken inside and outside the selected sector, which shows whether the sector lookup is applied. A long seeded random run then mixes the legal sequence bytes with noise and random engine flags. Each cycle is compared against a bench model, and this exposes errors in priority and in the return-state choice.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PGM_ADDR,
    S_ERS_UNL0, S_ERS_UNL1, S_ERS_UNL2, S_IDENT,
    S_PGM_BUSY, S_ERS_BUSY, S_SUSP, S_SUSP_UNL1,
    S_SUSP_UNL2, S_SUSP_PGM_ADDR, S_SUSP_PGM_BUSY, S_FAULT
  } cmd_state_e;

  typedef enum logic [1:0] {
    MODE_ARRAY   = 2'd0,
    MODE_IDENT   = 2'd1,
    MODE_STATUS  = 2'd2,
    MODE_SUSPEND = 2'd3
  } rd_mode_e;

  typedef struct packed {
    logic unl_a;
    logic unl_b;
    logic pgm;
    logic ers_setup;
    logic ers_chip;
    logic ers_sect;
    logic suspend;
    logic resume;
    logic ident;
    logic reset;
  } cycle_hits_t;

  function automatic rd_mode_e mode_of(cmd_state_e s);
    case (s)
      S_IDENT: return MODE_IDENT;
      S_PGM_BUSY, S_ERS_BUSY, S_SUSP_PGM_BUSY, S_FAULT: return MODE_STATUS;
      S_SUSP, S_SUSP_UNL1, S_SUSP_UNL2, S_SUSP_PGM_ADDR: return MODE_SUSPEND;
      default: return MODE_ARRAY;
    endcase
  endfunction

  function automatic logic in_suspend(cmd_state_e s);
    return (s == S_SUSP) || (s == S_SUSP_UNL1) || (s == S_SUSP_UNL2) ||
           (s == S_SUSP_PGM_ADDR) || (s == S_SUSP_PGM_BUSY);
  endfunction

endpackage

// File: rtl/fcs_cycle_decode.sv
module fcs_cycle_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned CMD_BITS      = 11,
  parameter int unsigned UNL_ADDR_A    = 'h555,
  parameter int unsigned UNL_ADDR_B    = 'h2AA,
  parameter logic [7:0]  UNL_DATA_A    = 8'hAA,
  parameter logic [7:0]  UNL_DATA_B    = 8'h55,
  parameter logic [7:0]  CODE_PGM      = 8'hA0,
  parameter logic [7:0]  CODE_ERS      = 8'h80,
  parameter logic [7:0]  CODE_CHIP     = 8'h10,
  parameter logic [7:0]  CODE_SECT     = 8'h30,
  parameter logic [7:0]  CODE_SUSPEND  = 8'hB0,
  parameter logic [7:0]  CODE_RESUME   = 8'h30,
  parameter logic [7:0]  CODE_IDENT    = 8'h90,
  parameter logic [7:0]  CODE_RESET    = 8'hF0
) (
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output cycle_hits_t   hits
);

  localparam logic [CMD_BITS-1:0] ADDR_A = CMD_BITS'(UNL_ADDR_A);
  localparam logic [CMD_BITS-1:0] ADDR_B = CMD_BITS'(UNL_ADDR_B);

  function automatic logic at_addr(logic [AW-1:0] a, logic [CMD_BITS-1:0] ref_a);
    return a[CMD_BITS-1:0] == ref_a;
  endfunction

  logic on_a, on_b;
  assign on_a = at_addr(wr_addr, ADDR_A);
  assign on_b = at_addr(wr_addr, ADDR_B);

  always_comb begin
    hits.unl_a     = on_a && (wr_data == UNL_DATA_A);
    hits.unl_b     = on_b && (wr_data == UNL_DATA_B);
    hits.pgm       = on_a && (wr_data == CODE_PGM);
    hits.ers_setup = on_a && (wr_data == CODE_ERS);
    hits.ers_chip  = on_a && (wr_data == CODE_CHIP);
    hits.ident     = on_a && (wr_data == CODE_IDENT);
    hits.ers_sect  = (wr_data == CODE_SECT);
    hits.suspend   = (wr_data == CODE_SUSPEND);
    hits.resume    = (wr_data == CODE_RESUME);
    hits.reset     = (wr_data == CODE_RESET);
  end

endmodule

// File: rtl/fcs_sector_track.sv
module fcs_sector_track #(
  parameter int unsigned AW      = 17,
  parameter int unsigned SECTORS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               load_all,
  input  logic [AW-1:0]      load_addr,
  input  logic [AW-1:0]      rd_addr,
  output logic [SECTORS-1:0] sel_q,
  output logic               rd_hit
);

  localparam int unsigned SBITS = $clog2(SECTORS);

  function automatic logic [SBITS-1:0] sector_of(logic [AW-1:0] a);
    return a[AW-1 -: SBITS];
  endfunction

  logic [SECTORS-1:0] one_hot;
  logic [SECTORS-1:0] rd_hot;

  for (genvar i = 0; i < SECTORS; i++) begin : g_dec
    assign one_hot[i] = (sector_of(load_addr) == SBITS'(i));
    assign rd_hot[i]  = (sector_of(rd_addr) == SBITS'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (load) sel_q <= load_all ? {SECTORS{1'b1}} : one_hot;
  end

  assign rd_hit = |(sel_q & rd_hot);

endmodule

// File: rtl/fcs_ctrl_fsm.sv
module fcs_ctrl_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  cycle_hits_t   hits,
  input  logic          prog_done,
  input  logic          erase_done,
  input  logic          eng_error,
  output cmd_state_e    st_q,
  output logic          prog_start,
  output logic          erase_start,
  output logic          erase_all,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          sect_load,
  output logic          sect_load_all,
  output logic          seq_abort,
  output logic          susp_abort
);

  cmd_state_e st_d;
  logic       pgm_go;

  always_comb begin
    st_d          = st_q;
    pgm_go        = 1'b0;
    sect_load     = 1'b0;
    sect_load_all = 1'b0;
    seq_abort     = 1'b0;
    susp_abort    = 1'b0;
    case (st_q)
      S_IDLE: if (wr_valid && hits.unl_a) st_d = S_UNL1;
      S_UNL1: if (wr_valid) begin
        if (hits.unl_b) st_d = S_UNL2;
        else begin st_d = S_IDLE; seq_abort = 1'b1; end
      end
      S_UNL2: if (wr_valid) begin
        if (hits.pgm)            st_d = S_PGM_ADDR;
        else if (hits.ers_setup) st_d = S_ERS_UNL0;
        else if (hits.ident)     st_d = S_IDENT;
        else begin st_d = S_IDLE; seq_abort = 1'b1; end
      end
      S_PGM_ADDR: if (wr_valid) begin
        pgm_go = 1'b1;
        st_d   = S_PGM_BUSY;
      end
      S_ERS_UNL0: if (wr_valid) begin
        if (hits.unl_a) st_d = S_ERS_UNL1;
        else begin st_d = S_IDLE; seq_abort = 1'b1; end
      end
      S_ERS_UNL1: if (wr_valid) begin
        if (hits.unl_b) st_d = S_ERS_UNL2;
        else begin st_d = S_IDLE; seq_abort = 1'b1; end
      end
      S_ERS_UNL2: if (wr_valid) begin
        if (hits.ers_chip) begin
          sect_load = 1'b1; sect_load_all = 1'b1; st_d = S_ERS_BUSY;
        end else if (hits.ers_sect) begin
          sect_load = 1'b1; st_d = S_ERS_BUSY;
        end else begin
          st_d = S_IDLE; seq_abort = 1'b1;
        end
      end
      S_IDENT: if (wr_valid && hits.reset) st_d = S_IDLE;
      S_PGM_BUSY: begin
        if (eng_error)      st_d = S_FAULT;
        else if (prog_done) st_d = S_IDLE;
      end
      S_ERS_BUSY: begin
        if (eng_error)                      st_d = S_FAULT;
        else if (erase_done)                st_d = S_IDLE;
        else if (wr_valid && hits.suspend)  st_d = S_SUSP;
      end
      S_SUSP: if (wr_valid) begin
        if (hits.unl_a)       st_d = S_SUSP_UNL1;
        else if (hits.resume) st_d = S_ERS_BUSY;
      end
      S_SUSP_UNL1: if (wr_valid) begin
        if (hits.unl_b) st_d = S_SUSP_UNL2;
        else begin st_d = S_SUSP; susp_abort = 1'b1; end
      end
      S_SUSP_UNL2: if (wr_valid) begin
        if (hits.pgm) st_d = S_SUSP_PGM_ADDR;
        else begin st_d = S_SUSP; susp_abort = 1'b1; end
      end
      S_SUSP_PGM_ADDR: if (wr_valid) begin
        pgm_go = 1'b1;
        st_d   = S_SUSP_PGM_BUSY;
      end
      S_SUSP_PGM_BUSY: begin
        if (eng_error)      st_d = S_FAULT;
        else if (prog_done) st_d = S_SUSP;
      end
      S_FAULT: if (wr_valid && hits.reset) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      erase_all   <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      st_q        <= st_d;
      prog_start  <= pgm_go;
      erase_start <= sect_load;
      if (sect_load) erase_all <= sect_load_all;
      if (pgm_go) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW           = 17,
  parameter int unsigned SECTORS      = 8,
  parameter int unsigned CMD_BITS     = 11,
  parameter int unsigned UNL_ADDR_A   = 'h555,
  parameter int unsigned UNL_ADDR_B   = 'h2AA,
  parameter logic [7:0]  UNL_DATA_A   = 8'hAA,
  parameter logic [7:0]  UNL_DATA_B   = 8'h55,
  parameter logic [7:0]  CODE_PGM     = 8'hA0,
  parameter logic [7:0]  CODE_ERS     = 8'h80,
  parameter logic [7:0]  CODE_CHIP    = 8'h10,
  parameter logic [7:0]  CODE_SECT    = 8'h30,
  parameter logic [7:0]  CODE_SUSPEND = 8'hB0,
  parameter logic [7:0]  CODE_RESUME  = 8'h30,
  parameter logic [7:0]  CODE_IDENT   = 8'h90,
  parameter logic [7:0]  CODE_RESET   = 8'hF0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [AW-1:0]      wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [AW-1:0]      rd_addr,
  input  logic               prog_done,
  input  logic               erase_done,
  input  logic               eng_error,
  output logic [1:0]         rd_mode,
  output logic               rd_is_status,
  output logic               prog_start,
  output logic               erase_start,
  output logic               erase_all,
  output logic               erase_hold,
  output logic [AW-1:0]      op_addr,
  output logic [7:0]         op_data,
  output logic [SECTORS-1:0] erase_sectors
);

  cycle_hits_t hits_w;
  cmd_state_e  st_w;
  logic        sect_load_w, sect_all_w, seq_abort_w, susp_abort_w, rd_hit_w;
  rd_mode_e    mode_w;

  fcs_cycle_decode #(
    .AW(AW), .CMD_BITS(CMD_BITS), .UNL_ADDR_A(UNL_ADDR_A), .UNL_ADDR_B(UNL_ADDR_B),
    .UNL_DATA_A(UNL_DATA_A), .UNL_DATA_B(UNL_DATA_B), .CODE_PGM(CODE_PGM),
    .CODE_ERS(CODE_ERS), .CODE_CHIP(CODE_CHIP), .CODE_SECT(CODE_SECT),
    .CODE_SUSPEND(CODE_SUSPEND), .CODE_RESUME(CODE_RESUME),
    .CODE_IDENT(CODE_IDENT), .CODE_RESET(CODE_RESET)
  ) u_dec (
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hits    (hits_w)
  );

  fcs_ctrl_fsm #(.AW(AW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .hits          (hits_w),
    .prog_done     (prog_done),
    .erase_done    (erase_done),
    .eng_error     (eng_error),
    .st_q          (st_w),
    .prog_start    (prog_start),
    .erase_start   (erase_start),
    .erase_all     (erase_all),
    .op_addr       (op_addr),
    .op_data       (op_data),
    .sect_load     (sect_load_w),
    .sect_load_all (sect_all_w),
    .seq_abort     (seq_abort_w),
    .susp_abort    (susp_abort_w)
  );

  fcs_sector_track #(.AW(AW), .SECTORS(SECTORS)) u_sect (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sect_load_w),
    .load_all  (sect_all_w),
    .load_addr (wr_addr),
    .rd_addr   (rd_addr),
    .sel_q     (erase_sectors),
    .rd_hit    (rd_hit_w)
  );

  assign mode_w       = mode_of(st_w);
  assign rd_mode      = mode_w;
  assign erase_hold   = in_suspend(st_w);
  assign rd_is_status = (mode_w == MODE_STATUS) || ((mode_w == MODE_SUSPEND) && rd_hit_w);

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import flash_cmd_pkg::*;
#(
  parameter int unsigned SECTORS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               prog_done,
  input logic               eng_error,
  input cycle_hits_t        hits,
  input cmd_state_e         st,
  input logic [1:0]         rd_mode,
  input logic               rd_is_status,
  input logic               prog_start,
  input logic               erase_start,
  input logic               erase_hold,
  input logic [SECTORS-1:0] erase_sectors,
  input logic               seq_abort,
  input logic               susp_abort
);

  p_start_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start));

  p_prog_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ($past(st) == S_PGM_ADDR || $past(st) == S_SUSP_PGM_ADDR));

  p_abort_array_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> rd_mode == 2'd0);

  p_abort_susp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    susp_abort |=> rd_mode == 2'd3);

  p_reset_array_r3: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_mode == 2'd0 && !prog_start && !erase_start));

  p_done_array_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PGM_BUSY && prog_done && !eng_error) |=> rd_mode == 2'd0);

  p_erase_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> erase_sectors != '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd3) |-> erase_hold);

  p_status_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd2) |-> rd_is_status);

  p_array_plain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode == 2'd0 || rd_mode == 2'd1) |-> !rd_is_status);

  p_ident_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDENT && !(wr_valid && hits.reset)) |=> st == S_IDENT);

  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FAULT && !(wr_valid && hits.reset)) |=> st == S_FAULT);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PGM_BUSY && !prog_done && !eng_error) |=> (st == S_PGM_BUSY && !prog_start));

endmodule

bind flash_cmd_seq fcs_checker #(.SECTORS(SECTORS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .prog_done     (prog_done),
  .eng_error     (eng_error),
  .hits          (hits_w),
  .st            (st_w),
  .rd_mode       (rd_mode),
  .rd_is_status  (rd_is_status),
  .prog_start    (prog_start),
  .erase_start   (erase_start),
  .erase_hold    (erase_hold),
  .erase_sectors (erase_sectors),
  .seq_abort     (seq_abort_w),
  .susp_abort    (susp_abort_w)
);

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic prog_done = 1'b0, erase_done = 1'b0, eng_error = 1'b0;
  logic [1:0] rd_mode;
  logic rd_is_status, prog_start, erase_start, erase_all, erase_hold;
  logic [AW-1:0] op_addr;
  logic [7:0] op_data, erase_sectors;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .prog_done(prog_done), .erase_done(erase_done), .eng_error(eng_error),
    .rd_mode(rd_mode), .rd_is_status(rd_is_status), .prog_start(prog_start),
    .erase_start(erase_start), .erase_all(erase_all), .erase_hold(erase_hold),
    .op_addr(op_addr), .op_data(op_data), .erase_sectors(erase_sectors)
  );

  int n_chk = 0, n_fail = 0;

  // reference model: 0 idle,1 u1,2 u2,3 pgm addr,4..6 erase unlock,7 ident,
  // 8 pgm busy,9 erase busy,10 susp,11 su1,12 su2,13 susp pgm addr,14 susp pgm busy,15 fault
  int m_st = 0;
  logic [7:0] m_sel = '0;
  bit m_ps = 0, m_es = 0, m_all = 0;
  logic [AW-1:0] m_pa = '0;
  logic [7:0] m_pd = '0;

  function automatic int exp_mode(int s);
    if (s == 7) return 1;
    if (s == 8 || s == 9 || s == 14 || s == 15) return 2;
    if (s >= 10 && s <= 13) return 3;
    return 0;
  endfunction

  function automatic bit cmd(logic [AW-1:0] a, logic [7:0] d, logic [10:0] ea, logic [7:0] ed);
    return (a[10:0] == ea) && (d == ed);
  endfunction

  function automatic bit exp_status(int s, logic [7:0] sel, logic [AW-1:0] ra);
    if (exp_mode(s) == 2) return 1'b1;
    if (exp_mode(s) == 3) return sel[ra[16:14]];
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit v, logic [AW-1:0] a, logic [7:0] d, bit pd, bit ed, bit er);
    int n;
    bit u1, u2;
    u1 = cmd(a, d, 11'h555, 8'hAA);
    u2 = cmd(a, d, 11'h2AA, 8'h55);
    n = m_st; m_ps = 0; m_es = 0;
    case (m_st)
      0: if (v && u1) n = 1;
      1: if (v) n = u2 ? 2 : 0;
      2: if (v) n = cmd(a, d, 11'h555, 8'hA0) ? 3 : cmd(a, d, 11'h555, 8'h80) ? 4 :
                    cmd(a, d, 11'h555, 8'h90) ? 7 : 0;
      3, 13: if (v) begin m_ps = 1; m_pa = a; m_pd = d; n = (m_st == 3) ? 8 : 14; end
      4: if (v) n = u1 ? 5 : 0;
      5: if (v) n = u2 ? 6 : 0;
      6: if (v) begin
        if (cmd(a, d, 11'h555, 8'h10)) begin m_es = 1; m_all = 1; m_sel = 8'hFF; n = 9; end
        else if (d == 8'h30) begin m_es = 1; m_all = 0; m_sel = 8'h01 << a[16:14]; n = 9; end
        else n = 0;
      end
      7, 15: if (v && d == 8'hF0) n = 0;
      8: if (er) n = 15; else if (pd) n = 0;
      14: if (er) n = 15; else if (pd) n = 10;
      9: if (er) n = 15; else if (ed) n = 0; else if (v && d == 8'hB0) n = 10;
      10: if (v) begin if (u1) n = 11; else if (d == 8'h30) n = 9; end
      11: if (v) n = u2 ? 12 : 10;
      12: if (v) n = cmd(a, d, 11'h555, 8'hA0) ? 13 : 10;
      default: n = 0;
    endcase
    m_st = n;
  endtask

  task automatic step(bit v, logic [AW-1:0] a, logic [7:0] d, bit pd, bit ed, bit er);
    wr_valid = v; wr_addr = a; wr_data = d;
    prog_done = pd; erase_done = ed; eng_error = er;
    @(posedge clk);
    model_edge(v, a, d, pd, ed, er);
    @(negedge clk);
    chk(rd_mode == 2'(exp_mode(m_st)), "R2 model rd_mode", rd_mode, exp_mode(m_st));
    chk(prog_start == m_ps, "R1 model prog_start", prog_start, m_ps);
    chk(erase_start == m_es, "R5 model erase_start", erase_start, m_es);
    chk(erase_hold == (exp_mode(m_st) == 3 || m_st == 14), "R6 model erase_hold",
        erase_hold, (exp_mode(m_st) == 3 || m_st == 14));
    chk(rd_is_status == exp_status(m_st, m_sel, rd_addr), "R7 model rd_is_status",
        rd_is_status, exp_status(m_st, m_sel, rd_addr));
    if (m_ps) begin
      chk(op_addr == m_pa, "R1 model op_addr", op_addr, m_pa);
      chk(op_data == m_pd, "R1 model op_data", op_data, m_pd);
    end
    if (m_es) begin
      chk(erase_all == m_all, "R5 model erase_all", erase_all, m_all);
      chk(erase_sectors == m_sel, "R5 model erase_sectors", erase_sectors, m_sel);
    end
    wr_valid = 0; prog_done = 0; erase_done = 0; eng_error = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    step(1, a, d, 0, 0, 0);
  endtask

  task automatic unlock();
    wr(17'h555, 8'hAA);
    wr(17'h2AA, 8'h55);
  endtask

  task automatic erase_setup();
    unlock();
    wr(17'h555, 8'h80);
    unlock();
  endtask

  logic [AW-1:0] seq_a [6];
  logic [7:0]    seq_d [6];

  initial begin
    void'($urandom(32'd4711));
    // R3 reset state
    repeat (3) @(negedge clk);
    chk(rd_mode == 2'd0, "R3 reset mode", rd_mode, 0);
    chk(!prog_start && !erase_start, "R3 reset starts", {prog_start, erase_start}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_mode == 2'd0, "R3 after reset mode", rd_mode, 0);

    // R1 program
    unlock(); wr(17'h555, 8'hA0); wr(17'h1_2345, 8'h3C);
    chk(prog_start == 1'b1, "R1 prog_start", prog_start, 1);
    chk(op_addr == 17'h1_2345 && op_data == 8'h3C, "R1 op fields", op_addr, 17'h1_2345);
    chk(rd_mode == 2'd2, "R1 busy mode", rd_mode, 2);
    // R11 writes while programming
    wr(17'h555, 8'hAA); wr(17'h2AA, 8'h55);
    chk(rd_mode == 2'd2 && !prog_start, "R11 busy ignore", rd_mode, 2);
    // R4 done
    step(0, 0, 0, 1, 0, 0);
    chk(rd_mode == 2'd0, "R4 prog done", rd_mode, 0);

    // R2 corrupted byte at each step of the erase sequence (program shares steps 0..1)
    seq_a[0] = 17'h555; seq_d[0] = 8'hAA; seq_a[1] = 17'h2AA; seq_d[1] = 8'h55;
    seq_a[2] = 17'h555; seq_d[2] = 8'h80; seq_a[3] = 17'h555; seq_d[3] = 8'hAA;
    seq_a[4] = 17'h2AA; seq_d[4] = 8'h55; seq_a[5] = 17'h555; seq_d[5] = 8'h10;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < k; j++) wr(seq_a[j], seq_d[j]);
      if (k % 2 == 0) wr(seq_a[k] ^ 17'h1, seq_d[k]);
      else            wr(seq_a[k], seq_d[k] ^ 8'h01);
      chk(rd_mode == 2'd0 && !erase_start, "R2 erase corrupt", rd_mode, 0);
    end
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < k; j++) wr(seq_a[j], seq_d[j]);
      wr(seq_a[k], (k == 2) ? 8'hA1 : (seq_d[k] ^ 8'h10));
      wr(17'h0_0100, 8'h12);
      chk(rd_mode == 2'd0 && !prog_start, "R2 program corrupt", rd_mode, 0);
    end

    // R5 chip erase
    erase_setup(); wr(17'h1_F555, 8'h10);
    chk(erase_start && erase_all, "R5 chip start", {erase_start, erase_all}, 3);
    chk(erase_sectors == 8'hFF, "R5 chip sectors", erase_sectors, 8'hFF);
    step(0, 0, 0, 0, 1, 0);
    chk(rd_mode == 2'd0, "R4 erase done", rd_mode, 0);

    // R5 sector erase in sector 2
    erase_setup(); wr(17'h0_9ABC, 8'h30);
    chk(erase_start && !erase_all, "R5 sector start", {erase_start, erase_all}, 2);
    chk(erase_sectors == 8'h04, "R5 sector bit", erase_sectors, 8'h04);
    // R6 suspend
    wr(17'h0_1234, 8'hB0);
    chk(rd_mode == 2'd3 && erase_hold, "R6 suspend", rd_mode, 3);
    // R7 suspended reads
    rd_addr = 17'h0_8010; step(0, 0, 0, 0, 0, 0);
    chk(rd_is_status == 1'b1, "R7 inside sector", rd_is_status, 1);
    rd_addr = 17'h1_4010; step(0, 0, 0, 0, 0, 0);
    chk(rd_is_status == 1'b0, "R7 outside sector", rd_is_status, 0);
    // R8 program while suspended
    unlock(); wr(17'h555, 8'hA0); wr(17'h1_4010, 8'h77);
    chk(prog_start && rd_mode == 2'd2, "R8 susp program", rd_mode, 2);
    step(0, 0, 0, 1, 0, 0);
    chk(rd_mode == 2'd3, "R8 back to suspend", rd_mode, 3);
    chk(rd_is_status == 1'b0, "R8 outside read", rd_is_status, 0);
    // R2 wrong cycle while suspended
    wr(17'h555, 8'hAA); wr(17'h2AA, 8'h56);
    chk(rd_mode == 2'd3, "R2 suspended abort", rd_mode, 3);
    // R6 resume
    wr(17'h0_0777, 8'h30);
    chk(rd_mode == 2'd2 && !erase_hold, "R6 resume", rd_mode, 2);
    step(0, 0, 0, 0, 1, 0);
    chk(rd_mode == 2'd0, "R4 resumed erase done", rd_mode, 0);

    // R9 identification
    unlock(); wr(17'h555, 8'h90);
    chk(rd_mode == 2'd1, "R9 ident enter", rd_mode, 1);
    wr(17'h555, 8'hAA); wr(17'h555, 8'h80);
    chk(rd_mode == 2'd1, "R9 ident ignores", rd_mode, 1);
    wr(17'h0_0000, 8'hF0);
    chk(rd_mode == 2'd0, "R9 ident exit", rd_mode, 0);

    // R10 error handling
    unlock(); wr(17'h555, 8'hA0); wr(17'h0_0042, 8'h99);
    step(0, 0, 0, 1, 0, 1);
    chk(rd_mode == 2'd2, "R10 error priority", rd_mode, 2);
    wr(17'h555, 8'hAA); step(0, 0, 0, 1, 1, 0);
    chk(rd_mode == 2'd2, "R10 error sticky", rd_mode, 2);
    wr(17'h1_0000, 8'hF0);
    chk(rd_mode == 2'd0, "R10 reset clears", rd_mode, 0);

    // seeded random mix against the model
    for (int i = 0; i < 6000; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      int r;
      a = AW'($urandom);
      r = int'($urandom % 12);
      case (r)
        0, 1: begin a[10:0] = 11'h555; d = 8'hAA; end
        2, 3: begin a[10:0] = 11'h2AA; d = 8'h55; end
        4: begin a[10:0] = 11'h555; d = 8'hA0; end
        5: begin a[10:0] = 11'h555; d = 8'h80; end
        6: begin a[10:0] = 11'h555; d = 8'h10; end
        7: d = 8'h30;
        8: d = 8'hB0;
        9: begin a[10:0] = 11'h555; d = 8'h90; end
        10: d = 8'hF0;
        default: d = 8'($urandom);
      endcase
      rd_addr = AW'($urandom);
      step(($urandom % 4) != 0, a, d, ($urandom % 6) == 0, ($urandom % 6) == 0,
           ($urandom % 40) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule